// File: doc/BRIEF.md
# Transmit-Only Serial Memory Streamer

This block serves the power-up phase of a small configuration memory. Until a host starts to talk on the two-wire bus, the device repeats its whole byte store on the serial data line, paced by a separate slow stream clock. Each byte takes nine stream-clock rising edges. The first eight edges put the data bits on the line, most significant bit first. The ninth edge releases the line for a filler bit. The read address then steps on by one, and it returns to zero after the top location.

The block fetches bytes through a valid/ready read port. It asks for the next byte while the filler bit is on the line. `rd_valid` stays high and `rd_addr` holds its value until the memory accepts with `rd_ready`. The byte is taken from `rd_data` in the cycle where both are high. The memory may hold `rd_ready` low for as long as it needs. A stream-clock edge that arrives before the next byte is loaded is dropped, so the bit sequence stays intact.

The block also watches the bus clock line. Streaming goes on only while that line, after synchronization, is high. A high-to-low transition on it moves the device into bidirectional mode for good. From then on the data line is released, no more fetches are made, and the mode flag stays set until reset. Both slow inputs pass through a two-flop synchronizer on the system clock, so the output responds within three system cycles of a stream-clock edge.

Top module: `tos_streamer`

## Requirements
- R1: While `rst_n` is low, `sda_drive_low` is 0, `bidir_mode` is 0, `rd_valid` is 1 and `rd_addr` is 0.
- R2: Each byte uses nine stream-clock rising edges. On edge k (k = 1..8), `sda_drive_low` becomes the inverse of data bit 8-k, so the MSB goes first and a 0 bit pulls the line low. On edge 9 (the filler), `sda_drive_low` becomes 0. The output changes within three system-clock cycles of the edge.
- R3: After the filler edge of a byte, `rd_addr` has moved up by exactly one. It never changes in any other way.
- R4: After location 127 is sent, `rd_addr` returns to 0, and the next byte streamed is the one at address 0.
- R5: While the synchronized bus clock line is low and no falling edge has been seen, stream-clock edges have no effect: `sda_drive_low` stays 0 and `rd_addr` does not change.
- R6: A falling edge on `bus_scl` sets `bidir_mode` within three system cycles. The flag then stays set until reset, even after later bus clock edges. While it is set, `sda_drive_low` is 0 and `rd_valid` is 0.
- R7: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_addr` stays stable in the next cycle. The byte streamed is the `rd_data` value seen in the handshake cycle.
- R8: A stream-clock edge that arrives while the next byte is not yet loaded is dropped. `sda_drive_low` stays unchanged, and once the byte arrives the next edge sends its MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the stream clock |
| rst_n | input | 1 | Active-low reset (supply-level reset) |
| strm_clk | input | 1 | Asynchronous slow stream clock, rising edge shifts a bit |
| bus_scl | input | 1 | Asynchronous two-wire bus clock line |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 7 | Read address |
| rd_data | input | 8 | Read data, sampled when rd_valid and rd_ready are both high |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| bidir_mode | output | 1 | 1 once the device has moved to bidirectional mode |

## Verification
The assertions check four rules on every cycle: the mode flag, once set, never clears; the data line stays released and no reads are requested in bidirectional mode; a stalled read request holds its address; and the address only ever steps by one. The bench scenarios cover what needs a model of the byte store and a count of edges. These are the MSB-first bit order with the released filler bit, the wrap from 127 to 0, stream edges ignored while the bus clock line is low from reset, and an edge dropped during a slow memory response without losing a bit.

// File: rtl/tos_pkg.sv
package tos_pkg;
  typedef enum logic {
    MODE_TX_ONLY = 1'b0,
    MODE_BIDIR   = 1'b1
  } mode_e;
endpackage

// File: rtl/tos_sync.sv
// Multi-stage level synchronizer for a slow asynchronous line.
module tos_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[0] <= 1'b0;
        else        q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= q[i-1];
      end
    end
  end

  assign level_o = q[STAGES-1];
endmodule

// File: rtl/tos_fetch.sv
// Address counter, valid/ready read request and one-byte holding register.
module tos_fetch #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              byte_done_i,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              have_byte_o,
  output logic [DATA_W-1:0] cur_byte_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              have_q;
  logic [DATA_W-1:0] byte_q;

  assign rd_valid    = !have_q && !halt_i;
  assign rd_addr     = addr_q;
  assign have_byte_o = have_q;
  assign cur_byte_o  = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      have_q <= 1'b0;
      byte_q <= '0;
    end else if (byte_done_i) begin
      addr_q <= addr_q + 1'b1;
      have_q <= 1'b0;
    end else if (rd_valid && rd_ready) begin
      byte_q <= rd_data;
      have_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tos_shifter.sv
// Bit counter and open-drain output register: DATA_W data bits then one filler.
module tos_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strm_level_i,
  input  logic              enable_i,
  input  logic              force_release_i,
  input  logic              have_byte_i,
  input  logic [DATA_W-1:0] cur_byte_i,
  output logic              byte_done_o,
  output logic              sda_low_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic             strm_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sda_q;
  logic             step;
  logic [DATA_W-1:0] aligned;

  assign step        = strm_level_i && !strm_prev_q;
  assign aligned     = cur_byte_i << cnt_q;
  assign byte_done_o = step && enable_i && !force_release_i && (cnt_q == LAST);
  assign sda_low_o   = sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strm_prev_q <= 1'b0;
    else        strm_prev_q <= strm_level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sda_q <= 1'b0;
    end else if (force_release_i) begin
      sda_q <= 1'b0;
    end else if (step && enable_i) begin
      if (cnt_q == LAST) begin
        sda_q <= 1'b0;
        cnt_q <= '0;
      end else if (have_byte_i) begin
        sda_q <= ~aligned[DATA_W-1];
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tos_streamer.sv
module tos_streamer #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strm_clk,
  input  logic              bus_scl,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_drive_low,
  output logic              bidir_mode
);
  import tos_pkg::*;

  logic              strm_s;
  logic              scl_s;
  logic              scl_prev_q;
  logic              scl_fall;
  mode_e             mode_q;
  logic              byte_done;
  logic              have_byte;
  logic [DATA_W-1:0] cur_byte;

  tos_sync #(.STAGES(SYNC_STAGES)) u_sync_strm (
    .clk(clk), .rst_n(rst_n), .async_i(strm_clk), .level_o(strm_s)
  );

  tos_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .async_i(bus_scl), .level_o(scl_s)
  );

  assign scl_fall   = scl_prev_q && !scl_s;
  assign bidir_mode = (mode_q == MODE_BIDIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b0;
      mode_q     <= MODE_TX_ONLY;
    end else begin
      scl_prev_q <= scl_s;
      if (scl_fall) mode_q <= MODE_BIDIR;
    end
  end

  tos_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .halt_i(bidir_mode), .byte_done_i(byte_done),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .have_byte_o(have_byte), .cur_byte_o(cur_byte)
  );

  tos_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .strm_level_i(strm_s),
    .enable_i(scl_s && !bidir_mode),
    .force_release_i(scl_fall || bidir_mode),
    .have_byte_i(have_byte), .cur_byte_i(cur_byte),
    .byte_done_o(byte_done), .sda_low_o(sda_drive_low)
  );
endmodule

// File: rtl/tos_streamer_chk.sv
module tos_streamer_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strm_clk,
  input logic              bus_scl,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              sda_drive_low,
  input logic              bidir_mode
);
  // R6: mode flag is sticky until reset
  a_r6_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |=> bidir_mode);

  // R6: line released in bidirectional mode
  a_r6_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |-> !sda_drive_low);

  // R6: no read requests in bidirectional mode
  a_r6_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |-> !rd_valid);

  // R7: a stalled request holds its address
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> ((rd_valid && $stable(rd_addr)) || bidir_mode));

  // R3: the address only steps by one (wrapping)
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));
endmodule

bind tos_streamer tos_streamer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_tos_streamer.sv
module test_tos_streamer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       strm_clk;
  logic       bus_scl;
  logic       rd_valid;
  logic       rd_ready;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       sda_drive_low;
  logic       bidir_mode;

  int checks = 0;
  int fails  = 0;
  int lag    = 0;
  int wcnt   = 0;
  int exp_addr = 0;

  // scenario table: {bytes to stream, memory ready lag in cycles}
  localparam int VEC [4][2] = '{'{3, 0}, '{2, 3}, '{4, 1}, '{1, 5}};

  always #5 clk = ~clk;

  tos_streamer i_tos_streamer (
    .clk(clk), .rst_n(rst_n), .strm_clk(strm_clk), .bus_scl(bus_scl),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_data(rd_data), .sda_drive_low(sda_drive_low), .bidir_mode(bidir_mode)
  );

  function automatic logic [7:0] mem_fn(input logic [6:0] a);
    return {a[0], a ^ 7'h2D};
  endfunction

  assign rd_data = mem_fn(rd_addr);

  initial rd_ready = 1'b0;
  always @(negedge clk) begin
    if (!rd_valid) begin
      wcnt = 0;
      rd_ready = 1'b0;
    end else begin
      rd_ready = (wcnt >= lag);
      wcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pulse();
    @(negedge clk) strm_clk = 1'b1;
    repeat (6) @(negedge clk);
    strm_clk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_byte();
    logic [7:0] d;
    d = mem_fn(7'(exp_addr));
    for (int i = 0; i < 9; i++) begin
      pulse();
      if (i < 8) chk(sda_drive_low == ~d[7-i], "R2 data bit", int'(sda_drive_low), int'(~d[7-i]));
      else       chk(sda_drive_low == 1'b0, "R2 filler", int'(sda_drive_low), 0);
    end
    exp_addr = (exp_addr + 1) % 128;
    if (exp_addr == 0) chk(rd_addr == 7'd0, "R4 wrap", int'(rd_addr), 0);
    else               chk(rd_addr == 7'(exp_addr), "R3 advance", int'(rd_addr), exp_addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    strm_clk = 1'b0;
    bus_scl  = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sda_drive_low == 1'b0, "R1 sda", int'(sda_drive_low), 0);
    chk(bidir_mode == 1'b0, "R1 mode", int'(bidir_mode), 0);
    chk(rd_valid == 1'b1, "R1 valid", int'(rd_valid), 1);
    chk(rd_addr == 7'd0, "R1 addr", int'(rd_addr), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5: bus clock low since reset, stream edges ignored
    for (int k = 0; k < 3; k++) begin
      pulse();
      chk(sda_drive_low == 1'b0, "R5 sda idle", int'(sda_drive_low), 0);
      chk(rd_addr == 7'd0, "R5 addr held", int'(rd_addr), 0);
      chk(bidir_mode == 1'b0, "R5 mode", int'(bidir_mode), 0);
    end
    bus_scl = 1'b1;
    repeat (5) @(negedge clk);

    // table walk: R2, R3, R7 under several memory lags
    for (int e = 0; e < 4; e++) begin
      lag = VEC[e][1];
      for (int b = 0; b < VEC[e][0]; b++) send_byte();
    end

    // R7 / R8: slow memory, dropped edge
    lag = 40;
    send_byte();
    chk(rd_valid == 1'b1, "R7 pending", int'(rd_valid), 1);
    pulse();
    chk(rd_valid == 1'b1, "R7 still pending", int'(rd_valid), 1);
    chk(rd_addr == 7'(exp_addr), "R7 addr stable", int'(rd_addr), exp_addr);
    chk(sda_drive_low == 1'b0, "R8 dropped edge", int'(sda_drive_low), 0);
    repeat (60) @(negedge clk);
    lag = 0;
    send_byte();  // R8: full byte from MSB after the drop

    // R4: run to the wrap and one byte past it
    while (exp_addr != 0) send_byte();
    send_byte();

    // R6: mode switch mid-byte
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pulse();
    chk(sda_drive_low == 1'b1, "R2 first MSB", int'(sda_drive_low), 1);
    @(negedge clk) bus_scl = 1'b0;
    repeat (4) @(negedge clk);
    chk(bidir_mode == 1'b1, "R6 mode set", int'(bidir_mode), 1);
    chk(sda_drive_low == 1'b0, "R6 released", int'(sda_drive_low), 0);
    pulse();
    chk(sda_drive_low == 1'b0, "R6 no stream", int'(sda_drive_low), 0);
    chk(rd_valid == 1'b0, "R6 no fetch", int'(rd_valid), 0);
    chk(rd_addr == 7'd0, "R6 addr frozen", int'(rd_addr), 0);
    bus_scl = 1'b1;
    repeat (5) @(negedge clk);
    bus_scl = 1'b0;
    repeat (5) @(negedge clk);
    chk(bidir_mode == 1'b1, "R6 sticky", int'(bidir_mode), 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(bidir_mode == 1'b0, "R1 mode cleared", int'(bidir_mode), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule